// File: doc/BRIEF.md
# Two-Wire Register Transaction Sequencer

This block runs complete register-style transactions on a two-wire bus master so that software does not have to step the master through each phase. It takes one command and then drives the master's control interface on its own. A command carries an operation, a 7-bit device address, a register address of zero to `REG_BYTES` bytes, and a byte count. The sequencer issues the start condition, the device address, the register-address bytes, an optional repeated start for reads, the data bytes and the stop condition.

After every step it waits for the master's step-complete flag and compares the master's status code with the code that a successful step produces. The wait is bounded by a cycle budget. The first mismatch or expired wait ends the transfer early. A stop is still issued, and a packed diagnostic word records the failing step. Write data comes in through a valid/ready byte port and read data leaves through another. Each command ends with a one-cycle `done` pulse, and `result` is valid while `done` is high.

The master is reached through one combined write strobe, which carries a control byte and a transmit byte, and through three inputs: the completion flag, the status code and the received byte. A control write clears the completion flag.

Top module: `twsq_seq`

## Requirements
- R1: A write (`cmd_op`=0; code 3 behaves the same way) issues these steps in order: START, device address with bit 0 = 0, the register-address bytes, each data byte taken from the write port, STOP.
- R2: A read (`cmd_op`=1) issues START, the device address with bit 0 = 0, the register-address bytes, a repeated START with no STOP before it, the device address with bit 0 = 1, `cmd_len` receive steps, then STOP. When `cmd_len` is 0 the receive steps are left out and the repeated START and address step still take place.
- R3: In a read, every receive step except the last requests ACK (control 0x44) and expects status 0x50. The last step requests NAK (control 0x40) and expects 0x58.
- R4: A probe (`cmd_op`=2) issues START, the device address with bit 0 = 1, one NAKed receive step whose byte is discarded, then STOP.
- R5: Register-address bytes go out most significant byte first, and there are `cmd_alen` of them (0 to `REG_BYTES`; larger values are clamped). The byte sent for the device address is {`cmd_dev`, R/W}.
- R6: Each data byte of a write is consumed in a cycle with `wr_valid` and `wr_ready` both high. Each received byte of a read is offered on `rd_data` with `rd_valid` and held stable until `rd_ready` is high.
- R7: Control encodings: START step 0x60, byte step 0x40 (0x44 for a receive with ACK), STOP 0x50. Expected status codes: start 0x08, repeated start 0x10, write address 0x18, sent byte 0x28, read address 0x40, received byte 0x50/0x58, idle after stop 0xF8. Each control write is followed by at least one cycle without a write.
- R8: The first status mismatch ends the transfer and a STOP follows next. `result` = {8'h01, last control byte with bit 3 set, observed status, expected status}. A later failure does not overwrite this value.
- R9: A step whose flag does not rise within `TICK_DIV*POLL_LIMIT` waiting cycles times out. `result` = {8'h02, last control byte, observed status, expected status}, and the STOP write comes `TICK_DIV*POLL_LIMIT+1` cycles after the hung step's write.
- R10: If the status does not reach 0xF8 within the same budget after STOP, the block sets `result` to {8'h02, 8'h50, observed status, 8'hF8}, but only when no earlier error was recorded.
- R11: `cmd_ready` is high only while idle. A `cmd_valid` that arrives while a transfer is running is ignored.
- R12: `done` is a one-cycle pulse that ends each command, with `result` valid during it. `result` is zero when every step succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; command taken when valid |
| cmd_op | input | 2 | 0 write, 1 read, 2 probe |
| cmd_dev | input | 7 | Device address |
| cmd_reg | input | 8*REG_BYTES | Register address |
| cmd_alen | input | clog2(REG_BYTES+1) | Register-address byte count |
| cmd_len | input | LEN_W | Data byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte consumed this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Command finished (one cycle) |
| result | output | 32 | Packed outcome, zero on success |
| m_ctrl_wr | output | 1 | Write strobe to the master |
| m_ctrl | output | 8 | Control byte for the master |
| m_wdata | output | 8 | Byte to transmit (zero for non-send steps) |
| m_flag | input | 1 | Master step-complete flag |
| m_status | input | 8 | Master status code |
| m_rdata | input | 8 | Byte received by the master |

## Verification
A wrong phase or a bad counter shows at the master interface by the next control write: the control byte or the transmitted byte is wrong, or a step is missing or added. This is visible a few cycles after the faulty transition. A fault in the wait logic shows as a result word with the wrong class or fields, or as a STOP write whose distance from the hung step differs from the budget. Both are visible at the next `done`. A fault in the read-byte path shows as corrupted or reordered bytes on the read port before `done`.

// File: rtl/twsq_pkg.sv
package twsq_pkg;

  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_READ = 2'd1, OP_PROBE = 2'd2} twsq_op_e;

  typedef enum logic [2:0] {
    PH_START, PH_DEVW, PH_REG, PH_RSTART, PH_DEVR, PH_DATW, PH_DATR, PH_STOP
  } twsq_ph_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_RDOUT, S_STOPW, S_DONE
  } twsq_st_e;

  // control byte bits
  localparam logic [7:0] CTL_ACK   = 8'h04;
  localparam logic [7:0] CTL_FLAG  = 8'h08;
  localparam logic [7:0] CTL_STOP  = 8'h10;
  localparam logic [7:0] CTL_START = 8'h20;
  localparam logic [7:0] CTL_EN    = 8'h40;

  // status codes of successful steps
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW     = 8'h18;
  localparam logic [7:0] ST_DW     = 8'h28;
  localparam logic [7:0] ST_AR     = 8'h40;
  localparam logic [7:0] ST_DR_ACK = 8'h50;
  localparam logic [7:0] ST_DR_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  localparam logic [7:0] CLS_MISMATCH = 8'h01;
  localparam logic [7:0] CLS_TIMEOUT  = 8'h02;

  function automatic logic [31:0] pack_result(input logic [7:0] cls, input logic [7:0] ctl,
                                              input logic [7:0] st, input logic [7:0] exp_st);
    return {cls, ctl, st, exp_st};
  endfunction

  // phase that follows the last address byte of the write-direction header
  function automatic twsq_ph_e after_addr(input twsq_op_e op, input logic len_more);
    if (op == OP_READ) return PH_RSTART;
    return len_more ? PH_DATW : PH_STOP;
  endfunction

  // alen_more / len_more describe the counts left after the current step
  function automatic twsq_ph_e next_phase(input twsq_ph_e ph, input twsq_op_e op,
                                          input logic alen_more, input logic len_more);
    case (ph)
      PH_START:  return (op == OP_PROBE) ? PH_DEVR : PH_DEVW;
      PH_DEVW,
      PH_REG:    return alen_more ? PH_REG : after_addr(op, len_more);
      PH_RSTART: return PH_DEVR;
      PH_DEVR:   return len_more ? PH_DATR : PH_STOP;
      PH_DATW:   return len_more ? PH_DATW : PH_STOP;
      PH_DATR:   return len_more ? PH_DATR : PH_STOP;
      default:   return PH_STOP;
    endcase
  endfunction

endpackage

// File: rtl/twsq_timeout.sv
module twsq_timeout #(
  parameter int TICK_DIV   = 500,
  parameter int POLL_LIMIT = 1000,
  localparam int LIMIT = TICK_DIV * POLL_LIMIT,
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twsq_decode.sv
module twsq_decode
  import twsq_pkg::*;
#(
  parameter int REG_BYTES = 4,
  localparam int ALEN_W = $clog2(REG_BYTES + 1)
) (
  input  twsq_ph_e                 ph,
  input  logic [6:0]               dev,
  input  logic [8*REG_BYTES-1:0]   reg_addr,
  input  logic [ALEN_W-1:0]        alen_left,
  input  logic                     last_byte,
  input  logic [7:0]               wr_data,
  output logic [7:0]               ctl,
  output logic [7:0]               tx_byte,
  output logic [7:0]               exp_code
);
  logic [7:0] reg_byte;

  // most significant remaining byte goes out first
  always_comb begin
    reg_byte = '0;
    for (int i = 0; i < REG_BYTES; i++)
      if (alen_left == ALEN_W'(i + 1)) reg_byte = reg_addr[8*i +: 8];
  end

  always_comb begin
    ctl      = CTL_EN;
    tx_byte  = '0;
    exp_code = ST_IDLE;
    case (ph)
      PH_START:  begin ctl = CTL_EN | CTL_START; exp_code = ST_START;  end
      PH_RSTART: begin ctl = CTL_EN | CTL_START; exp_code = ST_RSTART; end
      PH_DEVW:   begin tx_byte = {dev, 1'b0}; exp_code = ST_AW; end
      PH_DEVR:   begin tx_byte = {dev, 1'b1}; exp_code = ST_AR; end
      PH_REG:    begin tx_byte = reg_byte;    exp_code = ST_DW; end
      PH_DATW:   begin tx_byte = wr_data;     exp_code = ST_DW; end
      PH_DATR:   begin
        ctl      = last_byte ? CTL_EN : (CTL_EN | CTL_ACK);
        exp_code = last_byte ? ST_DR_NAK : ST_DR_ACK;
      end
      default:   begin ctl = CTL_EN | CTL_STOP; exp_code = ST_IDLE; end
    endcase
  end
endmodule

// File: rtl/twsq_seq.sv
module twsq_seq
  import twsq_pkg::*;
#(
  parameter int REG_BYTES  = 4,
  parameter int LEN_W      = 8,
  parameter int TICK_DIV   = 500,
  parameter int POLL_LIMIT = 1000,
  localparam int REG_W  = 8 * REG_BYTES,
  localparam int ALEN_W = $clog2(REG_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [6:0]        cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [ALEN_W-1:0] cmd_alen,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [31:0]       result,
  output logic              m_ctrl_wr,
  output logic [7:0]        m_ctrl,
  output logic [7:0]        m_wdata,
  input  logic              m_flag,
  input  logic [7:0]        m_status,
  input  logic [7:0]        m_rdata
);
  twsq_st_e          state;
  twsq_ph_e          phase;
  twsq_op_e          op;
  logic [6:0]        dev_q;
  logic [REG_W-1:0]  reg_q;
  logic [ALEN_W-1:0] alen_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        last_ctl;
  logic [7:0]        rdata_q;

  logic [7:0] ctl, tx_byte, exp_code;
  logic       expired;

  // named internal events, also used by the checker
  logic accept, issue_go, step_ok, step_bad, step_tmo, stop_idle, stop_tmo;
  logic [ALEN_W-1:0] alen_after;
  logic [LEN_W-1:0]  len_after;
  twsq_ph_e          nxt_phase;

  twsq_decode #(.REG_BYTES(REG_BYTES)) i_decode (
    .ph(phase), .dev(dev_q), .reg_addr(reg_q), .alen_left(alen_q),
    .last_byte(len_q == LEN_W'(1)), .wr_data(wr_data),
    .ctl(ctl), .tx_byte(tx_byte), .exp_code(exp_code)
  );

  twsq_timeout #(.TICK_DIV(TICK_DIV), .POLL_LIMIT(POLL_LIMIT)) i_timeout (
    .clk(clk), .rst_n(rst_n),
    .clr(state == S_ISSUE),
    .run(state == S_WAIT || state == S_STOPW),
    .expired(expired)
  );

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign issue_go  = (state == S_ISSUE) && ((phase != PH_DATW) || wr_valid);
  assign wr_ready  = issue_go && (phase == PH_DATW);
  assign m_ctrl_wr = issue_go;
  assign m_ctrl    = ctl;
  assign m_wdata   = tx_byte;

  assign step_ok   = (state == S_WAIT) && m_flag && (m_status == exp_code);
  assign step_bad  = (state == S_WAIT) && m_flag && (m_status != exp_code);
  assign step_tmo  = (state == S_WAIT) && !m_flag && expired;
  assign stop_idle = (state == S_STOPW) && (m_status == ST_IDLE);
  assign stop_tmo  = (state == S_STOPW) && !stop_idle && expired;

  assign rd_valid  = (state == S_RDOUT);
  assign rd_data   = rdata_q;
  assign done      = (state == S_DONE);

  assign alen_after = (phase == PH_REG) ? alen_q - 1'b1 : alen_q;
  assign len_after  = (phase == PH_DATW || phase == PH_DATR) ? len_q - 1'b1 : len_q;
  assign nxt_phase  = next_phase(phase, op, alen_after != '0, len_after != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= PH_START;
      op       <= OP_WRITE;
      dev_q    <= '0;
      reg_q    <= '0;
      alen_q   <= '0;
      len_q    <= '0;
      last_ctl <= '0;
      rdata_q  <= '0;
      result   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op     <= twsq_op_e'(cmd_op);
          dev_q  <= cmd_dev;
          reg_q  <= cmd_reg;
          alen_q <= (cmd_alen > ALEN_W'(REG_BYTES)) ? ALEN_W'(REG_BYTES) : cmd_alen;
          len_q  <= (twsq_op_e'(cmd_op) == OP_PROBE) ? LEN_W'(1) : cmd_len;
          result <= '0;
          phase  <= PH_START;
          state  <= S_ISSUE;
        end
        S_ISSUE: if (issue_go) begin
          last_ctl <= ctl;
          state    <= (phase == PH_STOP) ? S_STOPW : S_WAIT;
        end
        S_WAIT: begin
          if (step_ok) begin
            if (phase == PH_DATR && op != OP_PROBE) begin
              rdata_q <= m_rdata;
              state   <= S_RDOUT;
            end else begin
              phase  <= nxt_phase;
              alen_q <= alen_after;
              len_q  <= len_after;
              state  <= S_ISSUE;
            end
          end else if (step_bad || step_tmo) begin
            result <= pack_result(step_bad ? CLS_MISMATCH : CLS_TIMEOUT,
                                  step_bad ? (last_ctl | CTL_FLAG) : last_ctl,
                                  m_status, exp_code);
            phase  <= PH_STOP;
            state  <= S_ISSUE;
          end
        end
        S_RDOUT: if (rd_ready) begin
          phase  <= nxt_phase;
          alen_q <= alen_after;
          len_q  <= len_after;
          state  <= S_ISSUE;
        end
        S_STOPW: begin
          if (stop_idle) state <= S_DONE;
          else if (stop_tmo) begin
            if (result == '0) result <= pack_result(CLS_TIMEOUT, last_ctl, m_status, ST_IDLE);
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twsq_seq_chk.sv
module twsq_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        done,
  input logic [31:0] result,
  input logic        m_ctrl_wr,
  input logic [7:0]  m_ctrl,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [7:0]  rd_data,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        step_bad,
  input logic        step_tmo
);
  logic       err_seen;
  logic [7:0] last_written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_seen     <= 1'b0;
      last_written <= 8'h50;
    end else begin
      if (done) err_seen <= 1'b0;
      else if (step_bad || step_tmo) err_seen <= 1'b1;
      if (m_ctrl_wr) last_written <= m_ctrl;
    end
  end

  a_r7_ctrl_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    m_ctrl_wr |=> !m_ctrl_wr);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
  a_r11_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    m_ctrl_wr |-> !cmd_ready);
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r6_wr_take: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> wr_valid);
  a_r8_stop_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seen && m_ctrl_wr) |-> (m_ctrl == 8'h50));
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |=> $stable(result));
  a_r1_ends_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (last_written == 8'h50));
  a_r12_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[31:24] <= 8'h02));
endmodule

bind twsq_seq twsq_seq_chk i_twsq_seq_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .result(result),
  .m_ctrl_wr(m_ctrl_wr), .m_ctrl(m_ctrl), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .step_bad(step_bad), .step_tmo(step_tmo)
);

// File: tb/test_twsq_seq.sv
`timescale 1ns/1ps
module test_twsq_seq;
  localparam int RB = 4;
  localparam int LW = 8;
  localparam int TD = 2;
  localparam int PL = 8;
  localparam int BUDGET = TD * PL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [6:0] cmd_dev = '0;
  logic [31:0] cmd_reg = '0;
  logic [2:0] cmd_alen = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic done;
  logic [31:0] result;
  logic m_ctrl_wr;
  logic [7:0] m_ctrl, m_wdata;
  logic m_flag;
  logic [7:0] m_status, m_rdata;

  always #2.5 clk = ~clk;

  twsq_seq #(.REG_BYTES(RB), .LEN_W(LW), .TICK_DIV(TD), .POLL_LIMIT(PL)) i_twsq_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_alen(cmd_alen),
    .cmd_len(cmd_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .result(result), .m_ctrl_wr(m_ctrl_wr), .m_ctrl(m_ctrl), .m_wdata(m_wdata),
    .m_flag(m_flag), .m_status(m_status), .m_rdata(m_rdata)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // ---------------- bus master + device model ----------------
  logic [7:0] log_ctl [0:2047];
  logic [7:0] log_byte[0:2047];
  int         log_cyc [0:2047];
  int nlog = 0, cyc = 0;
  int inj_abs = -1, inj_kind = 0;
  bit hang_stop = 0;
  int pend = 0;
  bit pend_flag = 0, pend_stop = 0, in_tx = 0, exp_addr = 0, rw = 0;
  logic [7:0] pst, prd;
  logic [31:0] reg_acc = '0;
  int rd_i = 0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd29 + 32'd60;
    return t[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 1'b0; m_status <= 8'hF8; m_rdata <= 8'h00;
      pend = 0; in_tx = 0;
    end else begin
      cyc++;
      if (m_ctrl_wr) begin
        log_ctl[nlog] = m_ctrl; log_byte[nlog] = m_wdata; log_cyc[nlog] = cyc;
        m_flag <= 1'b0;
        pend_flag = 0; pend_stop = 0;
        pend = 1 + int'($urandom % 4);
        if (m_ctrl[5]) begin
          pst = in_tx ? 8'h10 : 8'h08; in_tx = 1; exp_addr = 1; pend_flag = 1;
        end else if (m_ctrl[4]) begin
          in_tx = 0; pend_stop = !hang_stop;
        end else if (exp_addr) begin
          rw = m_wdata[0]; exp_addr = 0; pend_flag = 1;
          pst = rw ? 8'h40 : 8'h18;
          if (!rw) reg_acc = '0;
          rd_i = 0;
        end else if (rw) begin
          pst = m_ctrl[2] ? 8'h50 : 8'h58; pend_flag = 1;
          prd = mem_byte(reg_acc + 32'(rd_i)); rd_i++;
        end else begin
          pst = 8'h28; pend_flag = 1; reg_acc = {reg_acc[23:0], m_wdata};
        end
        if (nlog == inj_abs) begin
          if (inj_kind == 1) pst = 8'h38;
          else pend_flag = 0;
        end
        nlog++;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (pend_flag) begin m_flag <= 1'b1; m_status <= pst; m_rdata <= prd; end
          if (pend_stop) m_status <= 8'hF8;
        end
      end
    end
  end

  // ---------------- data port drivers ----------------
  logic [7:0] wbuf[0:63];
  logic [7:0] rbuf[0:63];
  int widx = 0, wlen = 0, ridx = 0;

  initial forever begin
    @(negedge clk);
    wr_valid = (widx < wlen) && ($urandom % 4 != 0);
    wr_data  = wbuf[widx % 64];
    #1;
    if (wr_valid && wr_ready) widx++;
  end

  initial forever begin
    @(negedge clk);
    rd_ready = ($urandom % 3 != 0);
    #1;
    if (rd_valid && rd_ready) begin rbuf[ridx % 64] = rd_data; ridx++; end
  end

  // ---------------- expected sequence ----------------
  logic [7:0] ectl[0:63], ebyte[0:63], ecode[0:63];
  int nev;

  task automatic add_ev(input logic [7:0] c, input logic [7:0] b, input logic [7:0] s);
    ectl[nev] = c; ebyte[nev] = b; ecode[nev] = s; nev++;
  endtask

  task automatic build(input int op, input logic [6:0] dev, input logic [31:0] rg,
                       input int alen, input int len);
    nev = 0;
    add_ev(8'h60, 8'h00, 8'h08);
    if (op == 2) begin
      add_ev(8'h40, {dev, 1'b1}, 8'h40);
      add_ev(8'h40, 8'h00, 8'h58);
    end else begin
      add_ev(8'h40, {dev, 1'b0}, 8'h18);
      for (int a = alen - 1; a >= 0; a--) add_ev(8'h40, rg[8*a +: 8], 8'h28);
      if (op == 1) begin
        add_ev(8'h60, 8'h00, 8'h10);
        add_ev(8'h40, {dev, 1'b1}, 8'h40);
        for (int i = 0; i < len; i++)
          add_ev((i == len - 1) ? 8'h40 : 8'h44, 8'h00, (i == len - 1) ? 8'h58 : 8'h50);
      end else begin
        for (int i = 0; i < len; i++) add_ev(8'h40, wbuf[i], 8'h28);
      end
    end
    add_ev(8'h50, 8'h00, 8'hF8);
  endtask

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- one command ----------------
  task automatic run_cmd(input int op, input logic [6:0] dev, input logic [31:0] rg,
                         input int alen, input int len, input int inj_s, input int inj_k,
                         input bit hang, input bit poke, input string req);
    int base, n_exp, last_ok, mism;
    logic [31:0] exp_res, got;
    logic [7:0] xc[0:63], xb[0:63];
    logic [63:0] mask;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
    build(op, dev, rg, alen, len);
    ridx = 0; widx = 0; wlen = (op == 0) ? len : 0;
    base = nlog;
    inj_kind = inj_k; hang_stop = hang;
    inj_abs = (inj_s >= 0) ? base + inj_s : -1;
    @(negedge clk);
    cmd_op = 2'(op); cmd_dev = dev; cmd_reg = rg; cmd_alen = 3'(alen); cmd_len = LW'(len);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        check("R11", "ready while busy", 64'(cmd_ready), 64'd0);
        cmd_op = 2'd2; cmd_dev = ~dev; cmd_valid = 1'b1;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    got = result;
    // expected step list and result
    if (inj_s >= 0) begin
      for (int i = 0; i <= inj_s; i++) begin xc[i] = ectl[i]; xb[i] = ebyte[i]; end
      xc[inj_s + 1] = 8'h50; xb[inj_s + 1] = 8'h00; n_exp = inj_s + 2;
      if (inj_k == 1) exp_res = {8'h01, ectl[inj_s] | 8'h08, 8'h38, ecode[inj_s]};
      else exp_res = {8'h02, ectl[inj_s], (inj_s == 0) ? 8'hF8 : ecode[inj_s - 1], ecode[inj_s]};
    end else begin
      for (int i = 0; i < nev; i++) begin xc[i] = ectl[i]; xb[i] = ebyte[i]; end
      n_exp = nev;
      last_ok = nev - 2;
      exp_res = hang ? {8'h02, 8'h50, ecode[last_ok], 8'hF8} : 32'h0;
    end
    check(req, "step count", 64'(nlog - base), 64'(n_exp));
    mism = -1;
    for (int i = 0; i < n_exp; i++)
      if (mism < 0 && (log_ctl[base + i] !== xc[i] || log_byte[base + i] !== xb[i])) mism = i;
    if (mism >= 0) check(req, "step ctl/byte", {log_ctl[base + mism], log_byte[base + mism]},
                         {xc[mism], xb[mism]});
    else check(req, "step ctl/byte", 64'd0, 64'd0);
    check((inj_s >= 0 || hang) ? "R8/R9/R10" : "R12", "result word", 64'(got), 64'(exp_res));
    if (inj_s >= 0 && inj_k == 2)
      check("R9", "timeout gap", 64'(log_cyc[base + inj_s + 1] - log_cyc[base + inj_s]),
            64'(BUDGET + 1));
    if (inj_s < 0 && op == 1) begin
      mask = (64'd1 << (8 * alen)) - 1;
      check("R6", "read count", 64'(ridx), 64'(len));
      for (int i = 0; i < len; i++)
        check("R3", "read byte", 64'(rbuf[i]), 64'(mem_byte((rg & mask[31:0]) + 32'(i))));
    end
    if (op == 0 && inj_s < 0) check("R6", "write bytes taken", 64'(widx), 64'(len));
    @(negedge clk);
    check("R12", "done one cycle", 64'({done, cmd_ready}), 64'b01);
    inj_abs = -1; wlen = 0; hang_stop = 0;
  endtask

  initial begin
    int op, alen, len, s, k;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R12", "reset state", 64'({cmd_ready, done, m_ctrl_wr, rd_valid, wr_ready}),
          64'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corner cases
    run_cmd(0, 7'h50, 32'h0A0B0C0D, 4, 3, -1, 0, 0, 0, "R1 R5");
    run_cmd(1, 7'h21, 32'h00001234, 2, 4, -1, 0, 0, 0, "R2 R3");
    run_cmd(1, 7'h22, 32'h00000077, 1, 0, -1, 0, 0, 0, "R2 zero-length");
    run_cmd(1, 7'h23, 32'h00000000, 0, 1, -1, 0, 0, 0, "R3 single NAK");
    run_cmd(2, 7'h3C, 32'hFFFFFFFF, 3, 5, -1, 0, 0, 0, "R4");
    run_cmd(0, 7'h11, 32'h0, 0, 0, -1, 0, 0, 0, "R1 empty");
    run_cmd(0, 7'h12, 32'h55AA, 2, 2, -1, 0, 0, 1, "R11");
    run_cmd(1, 7'h13, 32'h99, 1, 3, 0, 2, 0, 0, "R9 start");
    run_cmd(1, 7'h14, 32'h99, 1, 3, 6, 1, 0, 0, "R8 last byte");
    run_cmd(0, 7'h15, 32'hBEEF, 2, 2, 3, 2, 0, 0, "R9 reg byte");
    // random mix
    for (int t = 0; t < 24; t++) begin
      op = int'($urandom % 3); alen = int'($urandom % 5); len = int'($urandom % 7);
      build(op, 7'h0, 32'h0, alen, len);
      s = -1; k = 0;
      if ($urandom % 4 == 0) begin s = int'($urandom % (nev - 1)); k = 1 + int'($urandom % 2); end
      run_cmd(op, 7'($urandom), $urandom, alen, len, s, k, 0, 0, "R1 R2 R4 random");
    end
    // stop that never reaches idle (kept last: the status stays off idle)
    run_cmd(0, 7'h16, 32'h1, 1, 1, 1, 1, 1, 0, "R10 earlier error kept");
    run_cmd(1, 7'h17, 32'h2, 1, 2, -1, 0, 1, 0, "R10 stop timeout");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog (all): actual hang expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule